// File: doc/BRIEF.md
# Predicate-Steered Two-Counter Branch Direction Predictor

This block predicts branch direction from a direct-mapped table. Each entry remembers which predicate register the branch tests, plus two 2-bit saturating counters. At lookup the stored register number is sent out to an external predicate register file. The one-bit value that comes back picks one of the two counters, and that counter's upper bit becomes the prediction. When the predicate is already final at fetch time (an early-resolved branch), the two counters learn the two directions apart and the prediction becomes exact. When the predicate carries no information, the pair behaves much like a single two-bit counter.

Lookups enter on a valid/ready request channel and return one cycle later on a registered valid/ready response channel. The response carries the predicate value that was used for selection, so the pipeline can hand it back unchanged when the branch resolves. The resolve channel reports the branch address, its predicate register number, that predicate value and the actual direction. Only the counter chosen by that predicate value is trained. A resolve that misses in the table allocates the entry first.

Top module: `pred_steer_bp`

## Requirements
- R1: After reset no entry is valid and `rsp_valid` is low; every lookup misses until a resolve allocates an entry.
- R2: A lookup that misses returns `rsp_hit`=0, `rsp_taken`=0 and `rsp_pval`=0, and drives `preg_rd_idx` to 0.
- R3: A resolve that misses writes the tag, the register number from `rs_preg`, TRUE counter 2'b10 and FALSE counter 2'b01. It then applies that resolve's outcome to the counter picked by `rs_pval`.
- R4: On a hit, `preg_rd_idx` carries the stored register number in the lookup cycle. The value on `preg_rd_val` in that cycle is returned as `rsp_pval` one cycle after the request is accepted.
- R5: On a hit, predicate 1 selects the TRUE counter and predicate 0 selects the FALSE counter. `rsp_taken` is bit 1 of the selected counter.
- R6: A resolve that hits updates only the counter picked by `rs_pval`: +1 on taken, -1 on not-taken. The other counter and the stored register number are kept; `rs_preg` is ignored on a hit.
- R7: Counters saturate at 0 and 3 and never wrap.
- R8: The entry index is the low log2(ENTRIES) address bits and the tag is the rest. A resolve whose tag differs from a valid entry at the same index replaces that entry, as in R3.
- R9: `lk_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay stable.
- R10: `rs_ready` is always high, and a resolve is applied on the edge where `rs_valid` is high. A lookup accepted on the same edge sees the table as it was before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_addr | input | ADDR_W | Branch address to predict |
| preg_rd_idx | output | log2(PREGS) | Predicate register number sent to the register file |
| preg_rd_val | input | 1 | Predicate value returned by the register file (same cycle) |
| rsp_valid | output | 1 | Prediction valid |
| rsp_ready | input | 1 | Consumer accepts the prediction |
| rsp_hit | output | 1 | Lookup found a matching entry |
| rsp_taken | output | 1 | Predicted direction |
| rsp_pval | output | 1 | Predicate value used for selection |
| rs_valid | input | 1 | Resolve valid |
| rs_ready | output | 1 | Resolve accepted (always high) |
| rs_addr | input | ADDR_W | Resolved branch address |
| rs_preg | input | log2(PREGS) | Predicate register the branch tests |
| rs_pval | input | 1 | Predicate value seen at prediction time |
| rs_taken | input | 1 | Actual branch direction |

## Verification
The bench starts with directed patterns. It makes a first lookup after allocation with the predicate both at 1 and at 0, which separates the two initial counter states. It sends long runs of one outcome to one counter while holding the predicate fixed; the direction that follows a run shows whether the counter wrapped and whether the other counter moved. It uses aliasing addresses at one index to expose tag-replacement errors, and it stalls the response to check that the fields hold. A long pseudo-random sweep over a small table then mixes indices, tags, register numbers, predicate-file contents and outcomes. Each prediction is compared with an arithmetic model of all counters, so a wrong selection, a wrong training target or a wrong returned predicate value shows up as a direction or field mismatch.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_TRUE_INIT  = 2'b10;
  localparam ctr2_t CTR_FALSE_INIT = 2'b01;
  localparam ctr2_t CTR_MAX        = 2'b11;
  localparam ctr2_t CTR_MIN        = 2'b00;
endpackage

// File: rtl/bp_ctr_step.sv
module bp_ctr_step
  import bp_pkg::*;
(
  input  ctr2_t cur,
  input  logic  taken,
  output ctr2_t nxt
);
  always_comb begin
    nxt = cur;
    if (taken && cur != CTR_MAX)
      nxt = cur + 2'd1;
    else if (!taken && cur != CTR_MIN)
      nxt = cur - 2'd1;
  end
endmodule

// File: rtl/bp_entry_table.sv
module bp_entry_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 1024,
  parameter int TAG_W   = 22,
  parameter int PRN_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_vld,
  output logic [TAG_W-1:0] a_tag,
  output logic [PRN_W-1:0] a_prn,
  output ctr2_t            a_ct,
  output ctr2_t            a_cf,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_vld,
  output logic [TAG_W-1:0] b_tag,
  output logic [PRN_W-1:0] b_prn,
  output ctr2_t            b_ct,
  output ctr2_t            b_cf,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [PRN_W-1:0] w_prn,
  input  ctr2_t            w_ct,
  input  ctr2_t            w_cf
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PRN_W-1:0]   prn_q [ENTRIES];
  ctr2_t              ct_q  [ENTRIES];
  ctr2_t              cf_q  [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n)
      vld_q <= '0;
    else if (we)
      vld_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[w_idx] <= w_tag;
      prn_q[w_idx] <= w_prn;
      ct_q[w_idx]  <= w_ct;
      cf_q[w_idx]  <= w_cf;
    end
  end

  assign a_vld = vld_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign a_prn = prn_q[a_idx];
  assign a_ct  = ct_q[a_idx];
  assign a_cf  = cf_q[a_idx];

  assign b_vld = vld_q[b_idx];
  assign b_tag = tag_q[b_idx];
  assign b_prn = prn_q[b_idx];
  assign b_ct  = ct_q[b_idx];
  assign b_cf  = cf_q[b_idx];
endmodule

// File: rtl/bp_rsp_stage.sv
module bp_rsp_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_hit,
  input  logic in_taken,
  input  logic in_pval,
  output logic out_valid,
  input  logic out_ready,
  output logic out_hit,
  output logic out_taken,
  output logic out_pval
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_taken <= 1'b0;
      out_pval  <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_hit   <= in_hit;
        out_taken <= in_taken;
        out_pval  <= in_pval;
      end
    end
  end
endmodule

// File: rtl/pred_steer_bp.sv
module pred_steer_bp
  import bp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 1024,
  parameter int PREGS   = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int PRN_W  = $clog2(PREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [PRN_W-1:0]  preg_rd_idx,
  input  logic              preg_rd_val,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_taken,
  output logic              rsp_pval,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic [PRN_W-1:0]  rs_preg,
  input  logic              rs_pval,
  input  logic              rs_taken
);
  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic             a_vld, b_vld;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [PRN_W-1:0] a_prn, b_prn;
  ctr2_t            a_ct, a_cf, b_ct, b_cf;

  assign lk_idx = lk_addr[IDX_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
  assign rs_idx = rs_addr[IDX_W-1:0];
  assign rs_tag = rs_addr[ADDR_W-1:IDX_W];

  // resolve side: merge allocation and training into one write
  logic             rs_hit;
  ctr2_t            base_ct, base_cf, cur_ctr, nxt_ctr, w_ct, w_cf;
  logic [PRN_W-1:0] w_prn;

  assign rs_hit  = b_vld && (b_tag == rs_tag);
  assign base_ct = rs_hit ? b_ct  : CTR_TRUE_INIT;
  assign base_cf = rs_hit ? b_cf  : CTR_FALSE_INIT;
  assign w_prn   = rs_hit ? b_prn : rs_preg;
  assign cur_ctr = rs_pval ? base_ct : base_cf;
  assign w_ct    = rs_pval ? nxt_ctr : base_ct;
  assign w_cf    = rs_pval ? base_cf : nxt_ctr;
  assign rs_ready = 1'b1;

  bp_ctr_step u_step (
    .cur   (cur_ctr),
    .taken (rs_taken),
    .nxt   (nxt_ctr)
  );

  bp_entry_table #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .PRN_W   (PRN_W)
  ) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .a_idx (lk_idx),
    .a_vld (a_vld),
    .a_tag (a_tag),
    .a_prn (a_prn),
    .a_ct  (a_ct),
    .a_cf  (a_cf),
    .b_idx (rs_idx),
    .b_vld (b_vld),
    .b_tag (b_tag),
    .b_prn (b_prn),
    .b_ct  (b_ct),
    .b_cf  (b_cf),
    .we    (rs_valid),
    .w_idx (rs_idx),
    .w_tag (rs_tag),
    .w_prn (w_prn),
    .w_ct  (w_ct),
    .w_cf  (w_cf)
  );

  // lookup side: predicate bit steers the counter mux
  logic lk_hit, lk_taken, lk_pval;

  assign lk_hit      = a_vld && (a_tag == lk_tag);
  assign preg_rd_idx = lk_hit ? a_prn : '0;
  assign lk_pval     = lk_hit && preg_rd_val;
  assign lk_taken    = lk_hit && (preg_rd_val ? a_ct[1] : a_cf[1]);

  bp_rsp_stage u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (lk_valid),
    .in_ready  (lk_ready),
    .in_hit    (lk_hit),
    .in_taken  (lk_taken),
    .in_pval   (lk_pval),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_hit   (rsp_hit),
    .out_taken (rsp_taken),
    .out_pval  (rsp_pval)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic lk_ready,
  input logic preg_rd_val,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic rsp_hit,
  input logic rsp_taken,
  input logic rsp_pval
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid);

  a_r2_miss_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_taken && !rsp_pval));

  a_r4_pval_returned: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (rsp_valid && (rsp_pval == ($past(preg_rd_val) && rsp_hit))));

  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);

  a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_taken) && $stable(rsp_pval)));
endmodule

bind pred_steer_bp bp_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_ready    (lk_ready),
  .preg_rd_val (preg_rd_val),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_hit     (rsp_hit),
  .rsp_taken   (rsp_taken),
  .rsp_pval    (rsp_pval)
);

// File: tb/pred_steer_bp_test.sv
module pred_steer_bp_test;
  localparam int AW = 12;
  localparam int NE = 16;
  localparam int NP = 8;
  localparam int IW = 4;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [AW-1:0] lk_addr = '0;
  logic [PW-1:0] preg_rd_idx;
  logic          preg_rd_val;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_hit, rsp_taken, rsp_pval;
  logic          rs_valid = 1'b0;
  logic          rs_ready;
  logic [AW-1:0] rs_addr = '0;
  logic [PW-1:0] rs_preg = '0;
  logic          rs_pval = 1'b0;
  logic          rs_taken = 1'b0;

  logic [NP-1:0] pfile = '0;
  assign preg_rd_val = pfile[preg_rd_idx];

  always #4 clk = ~clk;

  pred_steer_bp #(.ADDR_W(AW), .ENTRIES(NE), .PREGS(NP)) uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .preg_rd_idx(preg_rd_idx), .preg_rd_val(preg_rd_val),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_taken(rsp_taken), .rsp_pval(rsp_pval),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_addr(rs_addr),
    .rs_preg(rs_preg), .rs_pval(rs_pval), .rs_taken(rs_taken)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model
  bit            mv [NE];
  logic [AW-IW-1:0] mtag [NE];
  logic [PW-1:0] mpr [NE];
  logic [1:0]    mct [NE];
  logic [1:0]    mcf [NE];

  function automatic logic [1:0] sat(input logic [1:0] c, input bit t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic model_resolve(input logic [AW-1:0] a, input logic [PW-1:0] p, input bit pv, input bit t);
    int i = int'(a[IW-1:0]);
    if (!mv[i] || mtag[i] != a[AW-1:IW]) begin
      mv[i] = 1; mtag[i] = a[AW-1:IW]; mpr[i] = p; mct[i] = 2'd2; mcf[i] = 2'd1;
    end
    if (pv) mct[i] = sat(mct[i], t); else mcf[i] = sat(mcf[i], t);
  endtask

  task automatic expect_for(input logic [AW-1:0] a, output bit eh, output bit et, output bit ep);
    int i = int'(a[IW-1:0]);
    eh = mv[i] && (mtag[i] == a[AW-1:IW]);
    ep = eh && pfile[mpr[i]];
    et = eh && (ep ? mct[i][1] : mcf[i][1]);
  endtask

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got {vld,hit,taken,pval}=%b expected %b", req, got, exp);
    end
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, input string req, output bit gp);
    bit eh, et, ep;
    @(negedge clk);
    expect_for(a, eh, et, ep);
    lk_valid = 1; lk_addr = a;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
    check(req, {rsp_valid, rsp_hit, rsp_taken, rsp_pval}, {1'b1, eh, et, ep});
    gp = rsp_pval;
  endtask

  task automatic do_resolve(input logic [AW-1:0] a, input logic [PW-1:0] p, input bit pv, input bit t);
    @(negedge clk);
    rs_valid = 1; rs_addr = a; rs_preg = p; rs_pval = pv; rs_taken = t;
    @(posedge clk);
    model_resolve(a, p, pv, t);
    @(negedge clk);
    rs_valid = 0;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    bit gp;
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < NE; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 reset", {rsp_valid, lk_ready, rs_ready, 1'b0}, 4'b0110);
    rst_n = 1;
    do_lookup(12'h123, "R1 empty table", gp);
    // R2: miss
    do_lookup(12'h3A5, "R2 miss", gp);
    check("R2 preg idx on miss", {1'b0, preg_rd_idx}, 4'b0000);

    // R3: allocation, then first prediction for pv=1 and pv=0
    pfile[5] = 1;
    do_resolve(12'h045, 3'd5, 1'b1, 1'b1);   // T: 2->3
    do_lookup(12'h045, "R3 alloc TRUE side", gp);
    check("R4 returned pval", {3'b0, gp}, 4'b0001);
    pfile[5] = 0;
    do_lookup(12'h045, "R5 FALSE counter init", gp);  // F=1 -> not taken
    do_resolve(12'h046, 3'd2, 1'b0, 1'b1);   // F: 1->2 taken
    do_lookup(12'h046, "R3 alloc FALSE trained", gp);

    // R6: hit ignores rs_preg, only FALSE side moves
    do_resolve(12'h045, 3'd7, 1'b0, 1'b1);
    do_resolve(12'h045, 3'd7, 1'b0, 1'b1);
    pfile[7] = 0;
    do_lookup(12'h045, "R6 FALSE trained, stored preg kept", gp);
    pfile[5] = 1;
    do_lookup(12'h045, "R6 TRUE untouched", gp);

    // R7: saturation
    for (int k = 0; k < 5; k++) do_resolve(12'h047, 3'd1, 1'b1, 1'b1);
    pfile[1] = 1;
    do_resolve(12'h047, 3'd1, 1'b1, 1'b0);
    do_lookup(12'h047, "R7 saturate high", gp);
    for (int k = 0; k < 5; k++) do_resolve(12'h047, 3'd1, 1'b1, 1'b0);
    do_resolve(12'h047, 3'd1, 1'b1, 1'b1);
    do_lookup(12'h047, "R7 saturate low", gp);

    // R8: aliasing tag replaces
    do_resolve(12'h745, 3'd3, 1'b0, 1'b0);
    do_lookup(12'h045, "R8 old tag evicted", gp);
    do_lookup(12'h745, "R8 new tag", gp);

    // R9: back-pressure hold
    @(negedge clk);
    rsp_ready = 0; lk_valid = 1; lk_addr = 12'h046;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 0;
    for (int k = 0; k < 3; k++) begin
      check("R9 hold under stall", {rsp_valid, rsp_hit, rsp_taken, lk_ready}, 4'b1110);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R9 drained", {rsp_valid, lk_ready, 2'b00}, 4'b0100);

    // R10: same-edge lookup sees pre-update table
    pfile[2] = 0;
    begin
      bit eh, et, ep;
      @(negedge clk);
      expect_for(12'h046, eh, et, ep);
      lk_valid = 1; lk_addr = 12'h046;
      rs_valid = 1; rs_addr = 12'h046; rs_preg = 3'd2; rs_pval = 0; rs_taken = 0;
      @(posedge clk);
      model_resolve(12'h046, 3'd2, 1'b0, 1'b0);
      @(negedge clk);
      lk_valid = 0; rs_valid = 0;
      check("R10 same-edge lookup old state", {rsp_valid, rsp_hit, rsp_taken, rsp_pval}, {1'b1, eh, et, ep});
      do_resolve(12'h046, 3'd2, 1'b0, 1'b0);
      do_lookup(12'h046, "R10 resolve applied", gp);
    end

    // sweep: R4 R5 R6 R8 mixed
    for (int it = 0; it < 600; it++) begin
      logic [AW-1:0] a;
      logic [PW-1:0] p;
      bit pv, t, eh, et, ep;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {6'b0, lfsr[5:4], lfsr[3:0]};
      p = lfsr[8:6];
      pfile[lfsr[11:9]] = lfsr[12];
      expect_for(a, eh, et, ep);
      do_lookup(a, "R5 sweep prediction", gp);
      pv = eh ? gp : pfile[p];
      t  = lfsr[13] | lfsr[14];
      do_resolve(a, p, pv, t);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule